// File: doc/BRIEF.md
# Keyed Configuration Port

This block is a two-address configuration port for a peripheral controller. A byte-wide host bus carries an address, write data, a write strobe and a read strobe. The port decodes two addresses: an index port at the base address and a data port one above it. A register is reached by writing its number to the index port and then reading or writing the data port.

After reset the port is locked. It opens only when a four-byte key is written to the index port. The first three key bytes are fixed. The fourth depends on the base address the instance is built for. Once open, the port exposes a chip identifier, a logical device selector, a flash control byte and a 16-bit I/O base for the SPI controller device. The base is reachable only while that device is selected. The flash control byte and the SPI base are driven out continuously for the logic they configure. A dedicated write to register 0x02 locks the port again.

Top module: `cfg_port_unlock`

## Requirements
- R1: After reset the port is locked, `flash_ctl` and `spi_base` are 0x00 and 0x0000, and `rdata` is 0xFF.
- R2: Writing 0x87, 0x01, 0x55 and then the fourth key byte to the index port, on consecutive writes to that port, raises `unlocked` in the cycle after the fourth write.
- R3: A key byte that does not match the expected one returns the key tracker to its start. A sequence such as 0x87, 0x01, 0x00, 0x55, key4 leaves the port locked, and a full key written afterwards still opens it.
- R4: While the port is locked, a read of either port returns 0xFF, and data-port writes change no register.
- R5: When open, registers 0x20 and 0x21 read the high and low bytes of the CHIP_ID parameter (default 0x87 and 0x16).
- R6: Register 0x07 holds the logical device number. It can be written and read back, and the index port reads back the last index written.
- R7: With device 0x07 selected, registers 0x64 and 0x65 write and read the high and low bytes of `spi_base`. With any other device selected, writes to them are ignored and reads return 0x00.
- R8: Register 0x24 is the flash control byte. Bit 0 is suspend, bits 1 to 3 enable flash segments, bit 4 enables host writes to flash and bit 5 selects the flash pin. It is writable and readable only when open, and its value drives `flash_ctl`.
- R9: Writing 0x02 to register 0x02 locks the port in the next cycle. Any other value written there leaves the port open, and reopening it takes the full key.
- R10: `rdata` is loaded one cycle after a read strobe at either port and holds its value until the next such read.
- R11: Bus cycles at addresses other than the two decoded ones have no effect on the key, the registers or `rdata`.
- R12: The fourth key byte is 0x55 for base address 0x2E and 0xAA for any other base, such as 0x4E. The byte of the other base does not open the port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Registered read data |
| unlocked | output | 1 | High while configuration mode is open |
| flash_ctl | output | 8 | Flash control byte (register 0x24) |
| spi_base | output | 16 | SPI controller I/O base (device 0x07, registers 0x64/0x65) |

## Verification
Every result here is one register away from its strobe. `unlocked`, `flash_ctl` and `spi_base` change at the clock edge that samples the write, and `rdata` changes at the edge that samples the read. The bench drives each strobe for exactly one cycle, starting at a falling edge. It samples at the next falling edge, which is half a cycle after the edge that must produce the value, so no check depends on process order at that edge. A second instance built for base 0x4E shares the bus, so the same stimulus shows that the key byte depends on the base address.

// File: rtl/cfg_port_unlock.sv
module cfg_port_unlock #(
  parameter logic [15:0] BASE_ADDR = 16'h002E,
  parameter logic [15:0] CHIP_ID   = 16'h8716,
  parameter logic [7:0]  SPI_LDN   = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        wr,
  input  logic        rd,
  output logic [7:0]  rdata,
  output logic        unlocked,
  output logic [7:0]  flash_ctl,
  output logic [15:0] spi_base
);
  localparam logic [7:0]  KEY4     = (BASE_ADDR == 16'h002E) ? 8'h55 : 8'hAA;
  localparam logic [15:0] DATA_ADR = BASE_ADDR + 16'd1;

  typedef enum logic [2:0] {S_IDLE, S_K1, S_K2, S_K3, S_OPEN} st_t;
  st_t        st;
  logic [7:0] idx, ldn, rd_val;

  wire idx_hit = (addr == BASE_ADDR);
  wire dat_hit = (addr == DATA_ADR);
  wire wr_idx  = wr && idx_hit;
  wire wr_dat  = wr && dat_hit;
  wire spi_sel = (ldn == SPI_LDN);

  assign unlocked = (st == S_OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else case (st)
      S_IDLE: if (wr_idx) st <= (wdata == 8'h87) ? S_K1 : S_IDLE;
      S_K1:   if (wr_idx) st <= (wdata == 8'h01) ? S_K2 : S_IDLE;
      S_K2:   if (wr_idx) st <= (wdata == 8'h55) ? S_K3 : S_IDLE;
      S_K3:   if (wr_idx) st <= (wdata == KEY4)  ? S_OPEN : S_IDLE;
      S_OPEN: if (wr_dat && idx == 8'h02 && wdata == 8'h02) st <= S_IDLE;
      default: st <= S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= 8'h00;
      ldn       <= 8'h00;
      flash_ctl <= 8'h00;
      spi_base  <= 16'h0000;
    end else if (unlocked) begin
      if (wr_idx) idx <= wdata;
      if (wr_dat) begin
        case (idx)
          8'h07: ldn       <= wdata;
          8'h24: flash_ctl <= wdata;
          8'h64: if (spi_sel) spi_base[15:8] <= wdata;
          8'h65: if (spi_sel) spi_base[7:0]  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_val = 8'h00;
    if (!unlocked)    rd_val = 8'hFF;
    else if (idx_hit) rd_val = idx;
    else begin
      case (idx)
        8'h07: rd_val = ldn;
        8'h20: rd_val = CHIP_ID[15:8];
        8'h21: rd_val = CHIP_ID[7:0];
        8'h24: rd_val = flash_ctl;
        8'h64: rd_val = spi_sel ? spi_base[15:8] : 8'h00;
        8'h65: rd_val = spi_sel ? spi_base[7:0]  : 8'h00;
        default: rd_val = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= 8'hFF;
    else if (rd && (idx_hit || dat_hit)) rdata <= rd_val;
  end
endmodule

module cfg_port_unlock_chk #(
  parameter logic [15:0] BASE_ADDR = 16'h002E
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic [7:0]  wdata,
  input logic        wr,
  input logic        rd,
  input logic [7:0]  rdata,
  input logic        unlocked,
  input logic [7:0]  flash_ctl,
  input logic [15:0] spi_base
);
  localparam logic [7:0]  KEY4     = (BASE_ADDR == 16'h002E) ? 8'h55 : 8'hAA;
  localparam logic [15:0] DATA_ADR = BASE_ADDR + 16'd1;

  p_key_last_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr && addr == BASE_ADDR && wdata == KEY4));

  p_locked_reads_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && rd && (addr == BASE_ADDR || addr == DATA_ADR)) |=> rdata == 8'hFF);

  p_locked_ctl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(flash_ctl) && $stable(spi_base)));

  p_exit_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked) |-> $past(wr && addr == DATA_ADR && wdata == 8'h02));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

bind cfg_port_unlock cfg_port_unlock_chk #(.BASE_ADDR(BASE_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
  .rdata(rdata), .unlocked(unlocked), .flash_ctl(flash_ctl), .spi_base(spi_base)
);

// File: tb/cfg_port_unlock_tb.sv
module cfg_port_unlock_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata, rdata_b, rv;
  logic        unlocked, unlocked_b;
  logic [7:0]  flash_ctl, flash_ctl_b;
  logic [15:0] spi_base, spi_base_b;
  int checks = 0, fails = 0, cyc = 0;

  localparam logic [15:0] IX = 16'h002E, DT = 16'h002F;
  localparam logic [15:0] IXB = 16'h004E;

  always #2 clk = ~clk;

  cfg_port_unlock dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr(wr), .rd(rd), .rdata(rdata), .unlocked(unlocked),
    .flash_ctl(flash_ctl), .spi_base(spi_base));

  cfg_port_unlock #(.BASE_ADDR(16'h004E)) dut_b (.clk(clk), .rst_n(rst_n),
    .addr(addr), .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata_b),
    .unlocked(unlocked_b), .flash_ctl(flash_ctl_b), .spi_base(spi_base_b));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic key(input logic [15:0] a, input logic [7:0] k4);
    bus_wr(a, 8'h87); bus_wr(a, 8'h01); bus_wr(a, 8'h55); bus_wr(a, k4);
  endtask

  task automatic reg_wr(input logic [7:0] r, input logic [7:0] d);
    bus_wr(IX, r); bus_wr(DT, d);
  endtask

  task automatic reg_rd(input logic [7:0] r, output logic [7:0] d);
    bus_wr(IX, r); bus_rd(DT, d);
  endtask

  task automatic t_reset;
    check("R1 unlocked", {15'd0, unlocked}, 16'd0);
    check("R1 flash_ctl", {8'd0, flash_ctl}, 16'h0000);
    check("R1 spi_base", spi_base, 16'h0000);
    check("R1 rdata", {8'd0, rdata}, 16'h00FF);
  endtask

  task automatic t_locked;
    logic [7:0] d;
    bus_wr(IX, 8'h24); bus_wr(DT, 8'h5A);
    bus_rd(DT, d); check("R4 locked data read", {8'd0, d}, 16'h00FF);
    bus_rd(IX, d); check("R4 locked index read", {8'd0, d}, 16'h00FF);
    check("R4 flash_ctl untouched", {8'd0, flash_ctl}, 16'h0000);
  endtask

  task automatic t_unlock;
    bus_wr(IX, 8'h87); bus_wr(IX, 8'h01); bus_wr(IX, 8'h55);
    check("R2 not yet open", {15'd0, unlocked}, 16'd0);
    bus_wr(IX, 8'h55);
    check("R2 open after key", {15'd0, unlocked}, 16'd1);
  endtask

  task automatic t_bad_key;
    bus_wr(IX, 8'h87); bus_wr(IX, 8'h01); bus_wr(IX, 8'h00);
    bus_wr(IX, 8'h55); bus_wr(IX, 8'h55);
    check("R3 broken key stays locked", {15'd0, unlocked}, 16'd0);
    key(IX, 8'hAA);
    check("R12 wrong key4 for 0x2E", {15'd0, unlocked}, 16'd0);
  endtask

  task automatic t_id;
    logic [7:0] d;
    reg_rd(8'h20, d); check("R5 id high", {8'd0, d}, 16'h0087);
    reg_rd(8'h21, d); check("R5 id low", {8'd0, d}, 16'h0016);
    bus_rd(IX, d); check("R6 index readback", {8'd0, d}, 16'h0021);
  endtask

  task automatic t_ctl;
    logic [7:0] d;
    reg_rd(8'h24, d); check("R4 locked write ignored", {8'd0, d}, 16'h0000);
    reg_wr(8'h24, 8'h3E);
    check("R8 flash_ctl port", {8'd0, flash_ctl}, 16'h003E);
    reg_rd(8'h24, d); check("R8 reg 0x24 read", {8'd0, d}, 16'h003E);
  endtask

  task automatic t_spi;
    logic [7:0] d;
    reg_wr(8'h07, 8'h03);
    reg_wr(8'h64, 8'hAB);
    check("R7 other device write ignored", spi_base, 16'h0000);
    reg_rd(8'h64, d); check("R7 other device read 0", {8'd0, d}, 16'h0000);
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h07, d); check("R6 device readback", {8'd0, d}, 16'h0007);
    reg_wr(8'h64, 8'h0A); reg_wr(8'h65, 8'h20);
    check("R7 spi_base port", spi_base, 16'h0A20);
    reg_rd(8'h65, d); check("R7 low byte read", {8'd0, d}, 16'h0020);
  endtask

  task automatic t_other_addr;
    logic [7:0] d;
    reg_rd(8'h20, d);
    @(negedge clk); addr = 16'h0030; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    check("R11 foreign read keeps rdata", {8'd0, rdata}, 16'h0087);
    bus_wr(16'h002D, 8'h24); bus_wr(16'h0030, 8'hFF);
    check("R11 foreign write ignored", {8'd0, flash_ctl}, 16'h003E);
    repeat (3) @(negedge clk);
    check("R10 rdata holds", {8'd0, rdata}, 16'h0087);
  endtask

  task automatic t_exit;
    reg_wr(8'h02, 8'h01);
    check("R9 other value stays open", {15'd0, unlocked}, 16'd1);
    bus_wr(DT, 8'h02);
    check("R9 exit", {15'd0, unlocked}, 16'd0);
    bus_wr(IX, 8'h55);
    check("R9 no reopen without key", {15'd0, unlocked}, 16'd0);
    check("R9 flash_ctl kept", {8'd0, flash_ctl}, 16'h003E);
  endtask

  task automatic t_alt_base;
    key(IXB, 8'h55);
    check("R12 0x4E rejects 0x55", {15'd0, unlocked_b}, 16'd0);
    key(IXB, 8'hAA);
    check("R12 0x4E opens on 0xAA", {15'd0, unlocked_b}, 16'd1);
    check("R12 other instance untouched", {15'd0, unlocked}, 16'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <200000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_bad_key();
    t_unlock();
    t_id();
    t_ctl();
    t_spi();
    t_other_addr();
    t_exit();
    t_alt_base();
    bus_rd(DT, rv); check("R4 locked after exit", {8'd0, rv}, 16'h00FF);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule